// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is a byte-wide asynchronous serial port that software drives through a small 32-bit read/write register window. Bytes written to the data register are queued and sent on `txd` as 8N1 frames: one low start bit, eight data bits least significant first, and one high stop bit. Frames arriving on `rxd` are checked and queued for software to read from the same data register. A separate baud generator supplies `sample_tick` at `OVS` times the bit rate. The two baud settings held here are passed out to that generator on `baud_gen_o` and `baud_div_o`.

The control register holds a receive enable, a transmit enable, and two reset bits that clear themselves. One reset empties the transmit queue, the other empties the receive queue, and each returns its shifter to idle. The status register reports, as separate flags, that the receive queue is empty, that the transmit queue is empty, and that the transmitter is still sending a frame.

Transmit shifter states:
- `TX_IDLE`: goes to `TX_START` when transmit is enabled and the queue holds a byte. The byte is popped in that cycle.
- `TX_START`: goes to `TX_DATA` after `OVS` ticks.
- `TX_DATA`: goes to `TX_STOP` after the eighth bit period.
- `TX_STOP`: returns to `TX_IDLE` after `OVS` ticks.

Receive shifter states:
- `RX_IDLE`: goes to `RX_START` when receive is enabled and the line is low.
- `RX_START`: at half a bit period, goes to `RX_DATA` if the line is still low, and otherwise back to `RX_IDLE` (a glitch).
- `RX_DATA`: samples one bit every `OVS` ticks and goes to `RX_STOP` after eight bits.
- `RX_STOP`: samples the stop bit, stores the byte only if that bit is high, then goes to `RX_IDLE`.

Top module: `uart_regcore`

## Requirements
- R1: After reset, status (offset 0x2C) reads 0x00A, control reads 0, and `txd` is high.
- R2: Register offsets are fixed, and unmapped offsets read 0:
  - control is at 0x00;
  - mode is at 0x04, stores bits [10:0], and 0x20 selects 8 data bits with no parity;
  - baud generator value is at 0x18, bits [15:0];
  - baud divider value is at 0x34, bits [7:0].
  The baud generator and baud divider values appear on `baud_gen_o` and `baud_div_o`.
- R3: Control bit 1 resets the transmitter and bit 0 resets the receiver.
  - Both reset bits read back as 0.
  - The cycle after the write, each reset empties its own queue and returns its shifter to idle.
- R4: One control write may set both resets and both enables together. The resets act, and enable bits 2 (receive) and 4 (transmit) stay set afterwards.
- R5: Each transmitted frame is 8N1, least significant bit first, with every bit lasting `OVS` ticks. Frames are sent only while control bit 4 is set, and `txd` is high whenever no frame is being sent.
- R6: Status bit 11 reads 1 while a frame is being shifted out. Status bit 3 reads 1 when the transmit queue is empty, independently of bit 11.
- R7: The transmit queue holds 16 bytes. A data write to a full transmit queue is dropped.
- R8: Reading offset 0x30 pops the oldest received byte. When the receive queue is empty (status bit 1 reads 1), the read returns 0.
- R9: The receiver samples each bit in the middle of its period. It rejects a start pulse shorter than half a bit, and discards a frame whose stop bit is low.
- R10: While control bit 2 is clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at 0x30) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sample_tick | input | 1 | Oversampling tick, `OVS` per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| baud_gen_o | output | 16 | Baud generator setting to the external generator |
| baud_div_o | output | 8 | Baud divider setting to the external generator |

## Verification
The assertions check several properties on every cycle:
- `txd` rests high whenever the transmitter is idle;
- a reset bit written to control leaves its queue empty and its shifter idle two cycles later;
- the transmit enable survives a write that also carries resets;
- the transmit queue level never passes its depth;
- a data read from an empty receive queue returns 0.

Other behaviour shows only in the bench's scenarios:
- the serial framing, bit order and bit timing of transmitted bytes;
- the order in which bytes come back through the loopback;
- dropping of a sixteen-plus-two burst;
- rejection of a short start glitch and of a frame with a low stop bit;
- that a disabled receiver ignores traffic.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BGEN   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_BDIV   = 6'h34;

    // control bit positions
    localparam int CB_RX_RST = 0;
    localparam int CB_TX_RST = 1;
    localparam int CB_RX_EN  = 2;
    localparam int CB_TX_EN  = 4;

    // status bit positions
    localparam int SB_RX_EMPTY = 1;
    localparam int SB_TX_EMPTY = 3;
    localparam int SB_TX_BUSY  = 11;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_regcore_pkg::*;
#(
    parameter int OVS = 16,
    localparam int CW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       en,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd,
    output logic       busy
);
    tx_state_t state, nstate;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:0]    shreg;

    wire launch  = en && !q_empty;
    wire bit_end = tick && (cnt == CW'(OVS - 1));

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:  if (launch) nstate = TX_START;
            TX_START: if (bit_end) nstate = TX_DATA;
            TX_DATA:  if (bit_end && idx == 3'd7) nstate = TX_STOP;
            TX_STOP:  if (bit_end) nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (soft_rst) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= nstate;
            if (state == TX_IDLE) begin
                cnt <= '0;
                idx <= '0;
                if (launch) shreg <= q_data;
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (state == TX_DATA && bit_end) begin
                    shreg <= {1'b0, shreg[7:1]};
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        q_pop = (state == TX_IDLE) && launch && !soft_rst;
        busy  = (state != TX_IDLE);
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_regcore_pkg::*;
#(
    parameter int OVS = 16,
    localparam int CW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd_s,
    output logic       push,
    output logic [7:0] data
);
    rx_state_t state, nstate;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:0]    shreg;

    wire half_pt = tick && (cnt == CW'(OVS / 2 - 1));
    wire bit_end = tick && (cnt == CW'(OVS - 1));

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE:  if (en && !rxd_s) nstate = RX_START;
            RX_START: if (half_pt) nstate = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && idx == 3'd7) nstate = RX_STOP;
            RX_STOP:  if (bit_end) nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (soft_rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= nstate;
            if (state == RX_IDLE || (state == RX_START && half_pt)) begin
                cnt <= '0;
                idx <= '0;
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (state == RX_DATA && bit_end) begin
                    shreg <= {rxd_s, shreg[7:1]};
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        push = (state == RX_STOP) && bit_end && rxd_s;
        data = shreg;
    end
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
    import uart_regcore_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DEPTH  = 16,
    parameter int MODE_W = 11,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sample_tick,
    input  logic        rxd,
    output logic        txd,
    output logic [15:0] baud_gen_o,
    output logic [7:0]  baud_div_o
);
    logic              tx_en_q, rx_en_q, tx_rst_p, rx_rst_p;
    logic [MODE_W-1:0] mode_q;
    logic [15:0]       bgen_q;
    logic [7:0]        bdiv_q;
    logic [1:0]        rx_sync;

    logic             tx_empty, tx_full, tx_pop, tx_busy;
    logic [7:0]       tx_head;
    logic [LW-1:0]    tx_level;
    logic             rx_empty, rx_full, rx_push;
    logic [7:0]       rx_head, rx_byte;
    logic [LW-1:0]    rx_level;

    wire wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
    wire wr_data = bus_wr && bus_addr == OFS_DATA;
    wire rd_data = bus_rd && bus_addr == OFS_DATA;

    logic [15:0] unused_wdata;
    assign unused_wdata = bus_wdata[31:16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            tx_rst_p <= 1'b0;
            rx_rst_p <= 1'b0;
            mode_q   <= '0;
            bgen_q   <= '0;
            bdiv_q   <= '0;
            rx_sync  <= 2'b11;
        end else begin
            rx_sync  <= {rx_sync[0], rxd};
            tx_rst_p <= wr_ctrl && bus_wdata[CB_TX_RST];
            rx_rst_p <= wr_ctrl && bus_wdata[CB_RX_RST];
            if (wr_ctrl) begin
                tx_en_q <= bus_wdata[CB_TX_EN];
                rx_en_q <= bus_wdata[CB_RX_EN];
            end
            if (bus_wr && bus_addr == OFS_MODE) mode_q <= bus_wdata[MODE_W-1:0];
            if (bus_wr && bus_addr == OFS_BGEN) bgen_q <= bus_wdata[15:0];
            if (bus_wr && bus_addr == OFS_BDIV) bdiv_q <= bus_wdata[7:0];
        end
    end

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_rst_p),
        .push(wr_data && !tx_rst_p), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_rst_p),
        .push(rx_push), .wdata(rx_byte),
        .pop(rd_data), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .soft_rst(tx_rst_p), .en(tx_en_q),
        .tick(sample_tick), .q_empty(tx_empty), .q_data(tx_head),
        .q_pop(tx_pop), .txd(txd), .busy(tx_busy)
    );

    uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(rx_rst_p), .en(rx_en_q),
        .tick(sample_tick), .rxd_s(rx_sync[1]),
        .push(rx_push), .data(rx_byte)
    );

    logic unused_flags;
    assign unused_flags = ^{tx_full, rx_full, rx_level};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_TX_EN] = tx_en_q;
                bus_rdata[CB_RX_EN] = rx_en_q;
            end
            OFS_MODE: bus_rdata[MODE_W-1:0] = mode_q;
            OFS_BGEN: bus_rdata[15:0] = bgen_q;
            OFS_STATUS: begin
                bus_rdata[SB_RX_EMPTY] = rx_empty;
                bus_rdata[SB_TX_EMPTY] = tx_empty;
                bus_rdata[SB_TX_BUSY]  = tx_busy;
            end
            OFS_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            OFS_BDIV: bus_rdata[7:0] = bdiv_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign baud_gen_o = bgen_q;
    assign baud_div_o = bdiv_q;
endmodule

// File: rtl/uart_regcore_chk.sv
module uart_regcore_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [5:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          txd,
    input logic          tx_busy,
    input logic          tx_empty,
    input logic          rx_empty,
    input logic          tx_en_q,
    input logic [LW-1:0] tx_level
);
    assert_txd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_tx_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h00 && bus_wdata[1]) |=> ##1 (tx_empty && !tx_busy));

    assert_rx_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h00 && bus_wdata[0]) |=> ##1 rx_empty);

    assert_enable_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h00 && bus_wdata[4] && bus_wdata[1]) |=> ##1 tx_en_q);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 6'h30 && rx_empty) |-> bus_rdata == 32'h0);
endmodule

bind uart_regcore uart_regcore_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .tx_busy(tx_busy), .tx_empty(tx_empty), .rx_empty(rx_empty),
    .tx_en_q(tx_en_q), .tx_level(tx_level)
);

// File: tb/test_uart_regcore.sv
module test_uart_regcore;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sample_tick = 1'b1;
    logic        txd, rxd;
    logic        loop_sel = 1'b1;
    logic        rx_drv = 1'b1;
    logic [15:0] baud_gen_o;
    logic [7:0]  baud_div_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    assign rxd = loop_sel ? txd : rx_drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_regcore #(.OVS(OVS), .DEPTH(DEPTH)) i_uart_regcore (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sample_tick(sample_tick), .rxd(rxd), .txd(txd),
        .baud_gen_o(baud_gen_o), .baud_div_o(baud_div_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: queue a byte for transmission and the expected items
    task automatic send(input logic [7:0] b, input bit to_rx);
        txq.push_back(b);
        if (to_rx) rxq.push_back(b);
        wr(6'h30, {24'h0, b});
    endtask

    task automatic drain_tx();
        for (int i = 0; i < 40000 && txq.size() > 0; i++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic expect_rx(input string req);
        logic [31:0] d;
        logic [7:0]  e;
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
        rd(6'h30, d);
        check(d == {24'h0, e}, req, d, {24'h0, e});
    endtask

    task automatic raw_frame(input logic [7:0] b, input bit stop);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (OVS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (OVS) @(negedge clk);
        end
        rx_drv = stop;
        repeat (OVS) @(negedge clk);
        rx_drv = 1'b1;
        repeat (2 * OVS) @(negedge clk);
    endtask

    // monitor: decode txd at the pin and compare with the scoreboard queue
    initial begin : monitor
        logic [7:0] got;
        logic       st0, st1;
        logic [7:0] exp;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (OVS / 2) @(negedge clk);
                st0 = txd;
                for (int b = 0; b < 8; b++) begin
                    repeat (OVS) @(negedge clk);
                    got[b] = txd;
                end
                repeat (OVS) @(negedge clk);
                st1 = txd;
                if (txq.size() == 0) begin
                    check(1'b0, "R5 unexpected frame", {24'h0, got}, 32'h0);
                end else begin
                    exp = txq.pop_front();
                    check(got == exp && st0 == 1'b0 && st1 == 1'b1, "R5 frame",
                          {22'h0, st1, st0, got}, {22'h0, 2'b10, exp});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(6'h2C, d); check(d == 32'h00A, "R1 status", d, 32'h00A);
        rd(6'h00, d); check(d == 32'h0, "R1 control", d, 32'h0);
        check(txd == 1'b1, "R1 txd idle", {31'h0, txd}, 32'h1);

        // R2 register map
        wr(6'h04, 32'h20); rd(6'h04, d); check(d == 32'h20, "R2 mode", d, 32'h20);
        wr(6'h18, 32'hABCD1234); rd(6'h18, d); check(d == 32'h1234, "R2 bgen", d, 32'h1234);
        wr(6'h34, 32'h1FF); rd(6'h34, d); check(d == 32'hFF, "R2 bdiv", d, 32'hFF);
        check(baud_gen_o == 16'h1234 && baud_div_o == 8'hFF, "R2 baud outputs",
              {8'h0, baud_gen_o, baud_div_o}, 32'h001234FF);
        rd(6'h08, d); check(d == 32'h0, "R2 unmapped", d, 32'h0);

        // R3 R4 combined write: resets read 0, enables kept
        wr(6'h00, 32'h17); rd(6'h00, d); check(d == 32'h14, "R4 control readback", d, 32'h14);

        // R5 R6 transmit with loopback, status during shifting
        send(8'h55, 1'b1);
        repeat (3) @(negedge clk);
        rd(6'h2C, d); check(d[11] == 1'b1 && d[3] == 1'b1, "R6 busy with empty queue", d, 32'h80A);
        send(8'hA3, 1'b1); send(8'h00, 1'b1); send(8'hFF, 1'b1);
        drain_tx();
        rd(6'h2C, d); check(d[11] == 1'b0 && d[1] == 1'b0, "R6 idle, rx holds data", d, 32'h008);
        for (int i = 0; i < 4; i++) expect_rx("R8 loopback order");
        rd(6'h30, d); check(d == 32'h0, "R8 empty read", d, 32'h0);

        // R7 overflow with transmitter disabled
        wr(6'h00, 32'h04);
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i < DEPTH) begin
                txq.push_back(8'h30 + 8'(i));
                rxq.push_back(8'h30 + 8'(i));
            end
            wr(6'h30, 32'h30 + i);
        end
        rd(6'h2C, d); check(d[3] == 1'b0 && d[11] == 1'b0, "R5 held while disabled", d, 32'h002);
        wr(6'h00, 32'h14);
        drain_tx();
        for (int i = 0; i < DEPTH; i++) expect_rx("R7 sixteen kept");
        rd(6'h2C, d); check(d[1] == 1'b1, "R7 extras dropped", d, 32'h00A);

        // R3 transmit reset flushes queued bytes
        wr(6'h00, 32'h04);
        wr(6'h30, 32'h11); wr(6'h30, 32'h22); wr(6'h30, 32'h33);
        wr(6'h00, 32'h16);
        repeat (2) @(negedge clk);
        rd(6'h2C, d); check(d[3] == 1'b1 && d[11] == 1'b0, "R3 tx flushed", d, 32'h00A);
        repeat (400) @(negedge clk);
        send(8'h5A, 1'b1);
        drain_tx();
        expect_rx("R4 enable kept after reset");

        // R3 receive reset flushes received bytes
        send(8'hC7, 1'b0);
        drain_tx();
        rxq.push_back(8'h00);
        wr(6'h00, 32'h15);
        rd(6'h2C, d); check(d[1] == 1'b1, "R3 rx flushed", d, 32'h00A);
        expect_rx("R3 read after flush");

        // R10 receiver disabled
        wr(6'h00, 32'h10);
        send(8'h77, 1'b0);
        drain_tx();
        rd(6'h2C, d); check(d[1] == 1'b1, "R10 ignored", d, 32'h00A);

        // R9 framing errors and glitch with a driven line
        wr(6'h00, 32'h14);
        loop_sel = 1'b0;
        raw_frame(8'hC3, 1'b0);
        rd(6'h2C, d); check(d[1] == 1'b1, "R9 bad stop discarded", d, 32'h00A);
        @(negedge clk); rx_drv = 1'b0;
        repeat (OVS / 4) @(negedge clk); rx_drv = 1'b1;
        repeat (3 * OVS) @(negedge clk);
        rd(6'h2C, d); check(d[1] == 1'b1, "R9 glitch rejected", d, 32'h00A);
        raw_frame(8'h3C, 1'b1);
        rxq.push_back(8'h3C);
        expect_rx("R9 good frame");

        repeat (20) @(negedge clk);
        check(txq.size() == 0, "R5 all frames seen", txq.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule